// File: doc/BRIEF.md
# Debug instruction injection buffer

This block sits between a serial debug host and a halted CPU core. The host loads a short instruction, at most five bytes, into a set of byte-wide store registers through a register-write port. The core then reads those bytes back through an indexed byte-fetch port. Store slot 0 holds the first opcode byte and has the highest address of the five. An ascending burst of auto-incrementing writes therefore fills slots 4, 3, 2, 1 and ends on slot 0. That final write releases the core from halt with a one-cycle execute request. The core runs the single instruction, signals completion, and the block returns to the halted state to wait for the next injection.

The same address space holds a bus-control register with two bits. The enable bit decides whether external bus requests are honoured. When a request is honoured, the acknowledge waits until any injected instruction has finished. The force bit drives the bus-acknowledge output directly and hands the address and data buses to the external device.

Top module: `dbg_inject_buf`

## Requirements
- R1: After reset every store slot reads 0x00, the bus-control register reads 0x00, `core_halt` is 1, `exec_req` is 0 and `ext_busack` is 0.
- R2: A write to address A in 0..4 loads store slot 4-A. Fetch index i in 0..4 returns slot i with `fetch_err` 0. Addresses 5..7 and 9..15 change nothing.
- R3: With `wr_auto` set, a write goes to the previous write's address plus one, modulo 16, and `wr_addr` is ignored. Address 15 therefore continues at address 0.
- R4: A write to address 4 while halted makes `exec_req` 1 for exactly the one cycle after the write edge. In that same cycle `core_halt` drops to 0.
- R5: `core_done` while executing makes `core_halt` 1 from the next cycle. No further `exec_req` occurs until address 4 is written again.
- R6: While executing, writes to addresses 0..4 leave every slot unchanged, and a write to address 4 raises no new `exec_req`.
- R7: A fetch index of 5, 6 or 7 returns 0x00 with `fetch_err` 1.
- R8: While bus-control bit 7 (enable) is 0, `ext_busreq` never causes `ext_busack`.
- R9: While bit 7 is 1 and the core is halted, `ext_busack` rises one cycle after `ext_busreq` rises and falls one cycle after it is removed. A request made during execution is acknowledged one cycle after `core_halt` returns to 1.
- R10: Bus-control bit 6 drives `ext_busack` high regardless of requests. A write to bus-control (address 8) keeps only bits 7 and 6, and bits 5..0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_auto | input | 1 | Use previous address plus one instead of `wr_addr` |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| fetch_idx | input | 3 | Core byte-fetch index |
| fetch_data | output | 8 | Fetched instruction byte |
| fetch_err | output | 1 | Fetch index beyond the store |
| core_done | input | 1 | Core reports the injected instruction finished |
| core_halt | output | 1 | Core held in debug halt |
| exec_req | output | 1 | One-cycle execute request |
| ext_busreq | input | 1 | External bus request |
| ext_busack | output | 1 | Bus acknowledge to external device |
| ctl_rdata | output | 8 | Bus-control register readback |

## Verification
Every one of the sixteen write addresses is hit with a distinct byte. After each write, all eight fetch indices are read back against a bench model. This separates the reversed slot mapping, the ignored holes in the map and the out-of-range fetch path, and any write to address 4 must show the single execute pulse. An ascending auto-increment burst, plus a wrap from address 15 to 0, shows that the internal address counter rather than `wr_addr` chooses the target. Writes issued during execution show the lock. The bus requests are tried with the enable bit clear, with it set while halted, and with it set during execution, which tell apart ignoring, immediate granting and deferring to the end of the instruction.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;

  typedef enum logic [0:0] {
    RUN_HALTED = 1'b0,
    RUN_EXEC   = 1'b1
  } run_state_e;

  // Store slot k lives at address (nslots-1-k): first-fetched byte is highest.
  function automatic int unsigned slot_addr(input int unsigned slot,
                                            input int unsigned nslots);
    return nslots - 1 - slot;
  endfunction

  // Mask of bus-control bits that hold state: enable (msb) and force (msb-1).
  function automatic int unsigned ctl_keep_mask(input int unsigned width);
    return (1 << (width - 1)) | (1 << (width - 2));
  endfunction

endpackage

// File: rtl/dbg_inject_regs.sv
module dbg_inject_regs
  import dbg_inject_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int NUM_STORE = 5,
  parameter int CTL_ADDR  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_auto,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        store_lock,
  output logic [NUM_STORE*DATA_W-1:0] store_flat,
  output logic [DATA_W-1:0]           ctl_q,
  output logic                        trig_wr
);

  localparam logic [DATA_W-1:0] CTL_MASK  = DATA_W'(ctl_keep_mask(DATA_W));
  localparam logic [ADDR_W-1:0] CTL_A     = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] TRIG_A    = ADDR_W'(slot_addr(0, NUM_STORE));

  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr = wr_auto ? (last_addr + ADDR_W'(1)) : wr_addr;
  assign trig_wr  = wr_en && !store_lock && (eff_addr == TRIG_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_addr <= '0;
    else if (wr_en) last_addr <= eff_addr;
  end

  for (genvar k = 0; k < NUM_STORE; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(slot_addr(k, NUM_STORE));
    logic hit;
    assign hit = wr_en && !store_lock && (eff_addr == SLOT_A);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_flat[k*DATA_W +: DATA_W] <= '0;
      else if (hit) store_flat[k*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctl_q <= '0;
    else if (wr_en && (eff_addr == CTL_A)) ctl_q <= wr_data & CTL_MASK;
  end

endmodule

// File: rtl/dbg_inject_seq.sv
module dbg_inject_seq
  import dbg_inject_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_wr,
  input  logic core_done,
  output logic exec_req,
  output logic core_halt,
  output logic busy
);

  run_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RUN_HALTED;
      exec_req <= 1'b0;
    end else begin
      exec_req <= 1'b0;
      case (state)
        RUN_HALTED: if (trig_wr) begin
          state    <= RUN_EXEC;
          exec_req <= 1'b1;
        end
        RUN_EXEC: if (core_done) state <= RUN_HALTED;
        default:  state <= RUN_HALTED;
      endcase
    end
  end

  assign busy      = (state == RUN_EXEC);
  assign core_halt = !busy;

endmodule

// File: rtl/dbg_inject_fetch.sv
module dbg_inject_fetch #(
  parameter int DATA_W    = 8,
  parameter int NUM_STORE = 5,
  parameter int IDX_W     = 3
) (
  input  logic [IDX_W-1:0]            fetch_idx,
  input  logic [NUM_STORE*DATA_W-1:0] store_flat,
  output logic [DATA_W-1:0]           fetch_data,
  output logic                        fetch_err
);

  always_comb begin
    fetch_data = '0;
    for (int i = 0; i < NUM_STORE; i++) begin
      if (int'(fetch_idx) == i) fetch_data = store_flat[i*DATA_W +: DATA_W];
    end
    fetch_err = (int'(fetch_idx) >= NUM_STORE);
  end

endmodule

// File: rtl/dbg_inject_busgate.sv
module dbg_inject_busgate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_en,
  input  logic ack_force,
  input  logic busy,
  input  logic ext_busreq,
  output logic grant,
  output logic ext_busack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant <= 1'b0;
    else        grant <= req_en && ext_busreq && (grant || !busy);
  end

  assign ext_busack = ack_force || grant;

endmodule

// File: rtl/dbg_inject_buf.sv
module dbg_inject_buf #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int NUM_STORE = 5,
  parameter int CTL_ADDR  = 8,
  localparam int IDX_W    = $clog2(NUM_STORE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_auto,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic [DATA_W-1:0] fetch_data,
  output logic              fetch_err,
  input  logic              core_done,
  output logic              core_halt,
  output logic              exec_req,
  input  logic              ext_busreq,
  output logic              ext_busack,
  output logic [DATA_W-1:0] ctl_rdata
);

  localparam int EN_BIT  = DATA_W - 1;
  localparam int ACK_BIT = DATA_W - 2;

  logic [NUM_STORE*DATA_W-1:0] store_flat;
  logic [DATA_W-1:0]           ctl_q;
  logic                        trig_wr;
  logic                        busy;
  logic                        bus_grant;

  dbg_inject_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_STORE(NUM_STORE), .CTL_ADDR(CTL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_auto(wr_auto),
    .wr_addr(wr_addr), .wr_data(wr_data), .store_lock(busy),
    .store_flat(store_flat), .ctl_q(ctl_q), .trig_wr(trig_wr)
  );

  dbg_inject_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .core_done(core_done),
    .exec_req(exec_req), .core_halt(core_halt), .busy(busy)
  );

  dbg_inject_fetch #(
    .DATA_W(DATA_W), .NUM_STORE(NUM_STORE), .IDX_W(IDX_W)
  ) u_fetch (
    .fetch_idx(fetch_idx), .store_flat(store_flat),
    .fetch_data(fetch_data), .fetch_err(fetch_err)
  );

  dbg_inject_busgate u_bus (
    .clk(clk), .rst_n(rst_n), .req_en(ctl_q[EN_BIT]), .ack_force(ctl_q[ACK_BIT]),
    .busy(busy), .ext_busreq(ext_busreq), .grant(bus_grant), .ext_busack(ext_busack)
  );

  assign ctl_rdata = ctl_q;

endmodule

// File: rtl/dbg_inject_chk.sv
module dbg_inject_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_STORE = 5,
  parameter int IDX_W     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        trig_wr,
  input logic                        exec_req,
  input logic                        core_halt,
  input logic                        core_done,
  input logic [NUM_STORE*DATA_W-1:0] store_flat,
  input logic [IDX_W-1:0]            fetch_idx,
  input logic [DATA_W-1:0]           fetch_data,
  input logic                        fetch_err,
  input logic [DATA_W-1:0]           ctl_q,
  input logic                        bus_grant,
  input logic                        ext_busack
);

  AST_TRIG_GIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && core_halt) |=> (exec_req && !core_halt)); // R4
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |=> !exec_req); // R4
  AST_DONE_REHALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && core_done) |=> core_halt); // R5
  AST_STORE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt |=> $stable(store_flat)); // R6
  AST_FETCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fetch_idx) >= NUM_STORE) |-> (fetch_err && fetch_data == '0)); // R7
  AST_NO_ACK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[DATA_W-1] && $past(!ctl_q[DATA_W-1]) && !ctl_q[DATA_W-2]) |-> !ext_busack); // R8
  AST_GRANT_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(core_halt)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[DATA_W-3:0] == '0); // R10

endmodule

bind dbg_inject_buf dbg_inject_chk #(
  .DATA_W(DATA_W), .NUM_STORE(NUM_STORE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .exec_req(exec_req),
  .core_halt(core_halt), .core_done(core_done), .store_flat(store_flat),
  .fetch_idx(fetch_idx), .fetch_data(fetch_data), .fetch_err(fetch_err),
  .ctl_q(ctl_q), .bus_grant(bus_grant), .ext_busack(ext_busack)
);

// File: tb/dbg_inject_buf_bench.sv
module dbg_inject_buf_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_auto = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] fetch_idx = '0;
  logic [7:0] fetch_data;
  logic       fetch_err;
  logic       core_done = 1'b0;
  logic       core_halt, exec_req;
  logic       ext_busreq = 1'b0;
  logic       ext_busack;
  logic [7:0] ctl_rdata;

  int  compared = 0, mismatched = 0;
  bit  finished = 1'b0;
  logic [7:0] exp_store [5];
  logic [7:0] exp_ctl;
  logic [3:0] bench_last;
  bit         exp_halt;

  always #10 clk = ~clk;

  dbg_inject_buf u_dbg_inject_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_auto(wr_auto),
    .wr_addr(wr_addr), .wr_data(wr_data), .fetch_idx(fetch_idx),
    .fetch_data(fetch_data), .fetch_err(fetch_err), .core_done(core_done),
    .core_halt(core_halt), .exec_req(exec_req), .ext_busreq(ext_busreq),
    .ext_busack(ext_busack), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of a write; returns 1 if an execute pulse is expected.
  function automatic bit model_wr(input logic [3:0] a, input logic [7:0] d);
    bit fire = 1'b0;
    if (a < 4'd5 && exp_halt) begin
      exp_store[4 - a] = d;
      if (a == 4'd4) begin fire = 1'b1; exp_halt = 1'b0; end
    end
    if (a == 4'd8) exp_ctl = d & 8'hC0;
    bench_last = a;
    return fire;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit aut);
    @(negedge clk);
    wr_en = 1'b1; wr_auto = aut; wr_addr = aut ? 4'hA : a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_auto = 1'b0;
  endtask

  task automatic check_fetch(input string req);
    for (int i = 0; i < 8; i++) begin
      fetch_idx = 3'(i);
      #1;
      chk(req, fetch_data, (i < 5) ? exp_store[i] : 8'h00);
      chk(req, fetch_err, (i >= 5));
    end
  endtask

  task automatic finish_exec(input string req);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    exp_halt = 1'b1;
    chk(req, core_halt, 1);
    chk(req, exec_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit fire;
    logic [7:0] d;
    for (int i = 0; i < 5; i++) exp_store[i] = 8'h00;
    exp_ctl = 8'h00; exp_halt = 1'b1; bench_last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_fetch("R1");
    chk("R1 halt", core_halt, 1); chk("R1 req", exec_req, 0);
    chk("R1 ack", ext_busack, 0); chk("R1 ctl", ctl_rdata, 8'h00);

    // R3 ascending burst 0..4 loads slots 4..0, last write triggers (R4)
    wr(4'd0, 8'hA4, 0); void'(model_wr(4'd0, 8'hA4));
    for (int k = 1; k < 5; k++) begin
      d = 8'hB0 + 8'(k);
      wr(4'd0, d, 1);
      fire = model_wr(bench_last + 4'd1, d);
      chk("R4 req", exec_req, fire);
      chk("R4 halt", core_halt, !fire);
    end
    @(negedge clk);
    chk("R4 single pulse", exec_req, 0);
    check_fetch("R3 R2 R7");

    // R6 writes during execution ignored
    wr(4'd2, 8'hEE, 0); void'(model_wr(4'd2, 8'hEE));
    chk("R6 no req", exec_req, 0);
    wr(4'd4, 8'h55, 0); void'(model_wr(4'd4, 8'h55));
    chk("R6 no req", exec_req, 0);
    check_fetch("R6");

    // R5 completion returns to halt, no spontaneous request
    finish_exec("R5");
    repeat (4) begin @(negedge clk); chk("R5 idle", exec_req, 0); end

    // R2 sweep of all addresses
    for (int a = 0; a < 16; a++) begin
      d = 8'((a * 37 + 11) & 8'hFF);
      wr(4'(a), d, 0);
      fire = model_wr(4'(a), d);
      chk("R2 R4 req", exec_req, fire);
      if (fire) finish_exec("R2 R5");
      check_fetch("R2");
      chk("R2 R10 ctl", ctl_rdata, exp_ctl);
      chk("R10 ack", ext_busack, exp_ctl[6]);
    end

    // R3 wrap 15 -> 0
    wr(4'd15, 8'h11, 0); void'(model_wr(4'd15, 8'h11));
    wr(4'd0, 8'h77, 1); void'(model_wr(4'd0, 8'h77));
    check_fetch("R3 wrap");

    // R8 disabled requests ignored
    wr(4'd8, 8'h00, 0); void'(model_wr(4'd8, 8'h00));
    ext_busreq = 1'b1;
    repeat (3) begin @(negedge clk); chk("R8 ack", ext_busack, 0); end
    // R10 force bit and reserved bits
    wr(4'd8, 8'h7F, 0); void'(model_wr(4'd8, 8'h7F));
    chk("R10 ctl", ctl_rdata, 8'h40); chk("R10 ack", ext_busack, 1);
    ext_busreq = 1'b0;
    wr(4'd8, 8'hBF, 0); void'(model_wr(4'd8, 8'hBF));
    chk("R10 ctl", ctl_rdata, 8'h80); chk("R9 ack idle", ext_busack, 0);

    // R9 grant while halted
    ext_busreq = 1'b1;
    @(negedge clk); chk("R9 grant", ext_busack, 1);
    ext_busreq = 1'b0;
    @(negedge clk); chk("R9 release", ext_busack, 0);

    // R9 request during execution deferred
    wr(4'd4, 8'h3C, 0); fire = model_wr(4'd4, 8'h3C);
    chk("R9 exec", exec_req, fire);
    ext_busreq = 1'b1;
    repeat (3) begin @(negedge clk); chk("R9 deferred", ext_busack, 0); end
    finish_exec("R9 R5");
    chk("R9 still deferred", ext_busack, 0);
    @(negedge clk); chk("R9 granted", ext_busack, 1);
    ext_busreq = 1'b0;
    @(negedge clk); chk("R9 release", ext_busack, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule